// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block controls eight pins for an external pad ring. Each pin has four settings: a direction, a port output value, an open-drain or push-pull driver mode, and a 2-bit source select. The source select either keeps the pin on the port output value or hands it to one of three peripheral outputs. The block gives each pad an output value and an output-enable. It takes the raw pad level in through a two-flop synchronizer. The synchronized level is always readable through the register interface and is also passed in parallel to peripheral inputs.

Every access carries a pin mask in its upper address bits, so each mask pattern has its own address. A write changes only the pins whose mask bit is set. A read returns only the selected pins. Software can therefore change one pin without a read-modify-write sequence, and without disturbing pins that other software owns.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, every setting register reads 0, so pad_oe is 0 for every pin (all pins are inputs with drivers off).
- R2: bus_addr[2:0] selects a register: 0 = port output value, 1 = direction (1 = output), 2 = driver mode (1 = open-drain), 3 = source-select bit 0, 4 = source-select bit 1, 5 = synchronized pin level (read-only). bus_addr[10:3] is the pin mask. On a write (bus_en and bus_we high at a rising edge), each bit whose mask bit is 1 takes the corresponding bus_wdata bit.
- R3: On a write, every bit whose mask bit is 0 keeps its previous value. A mask of 0 changes nothing.
- R4: While bus_en is high and bus_we is low, bus_rdata shows the selected register ANDed with the mask in the same cycle. Register addresses 6 and 7 read as 0. While no read is in progress, bus_rdata is 0.
- R5: The value read from register 5 is the pad_in level sampled at the second rising edge after it was applied. The source select and direction of the pin have no effect on this.
- R6: periph_in carries the same synchronized pin level as register 5, with the same two-edge latency.
- R7: For a pin with source select 0 in push-pull mode, pad_out equals the port output bit and pad_oe equals the direction bit.
- R8: For source select k (1..3), the pin takes its value from alt_out[(k-1)*8+i] and its enable from alt_oe[(k-1)*8+i].
- R9: In open-drain mode, pad_out is 0. pad_oe is 1 only when the selected source is enabled and its value is 0.
- R10: Writes to register addresses 5, 6 and 7 change no setting and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | {pin mask[7:0], register select[2:0]} |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Masked read data |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output-enables |
| alt_out | input | 24 | Peripheral output values, three groups of 8 |
| alt_oe | input | 24 | Peripheral output-enables, three groups of 8 |
| periph_in | output | 8 | Synchronized pin levels to peripherals |

## Verification
The bench attacks mask handling with writes whose masks are zero, full, or random. A design that merged the write data without the mask would corrupt neighbouring pins, and the bench would see this in the pad outputs and in read-back. Open-drain pins are driven with ones and zeros under both port and peripheral sources. A driver that pushed a 1 high, or that ignored the source enable, would show a wrong pad_oe or a high pad_out. The bench also counts the synchronizer latency edge by edge, writes to the read-only pin register, and reads the unused addresses. These catch a design with one flop too few, a writable input register, or stale data leaking onto the read bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int SEL_W = 3;
    localparam int ALT_N = 3;

    typedef enum logic [SEL_W-1:0] {
        RS_DOUT = 3'd0,
        RS_DIR  = 3'd1,
        RS_OD   = 3'd2,
        RS_ALO  = 3'd3,
        RS_AHI  = 3'd4,
        RS_PIN  = 3'd5
    } regsel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R5 R6: two rising edges between pad and synchronized level
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> sync_o == $past(async_i, 2));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  regsel_e         sel,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dout_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] od_q,
    output logic [PINS-1:0] alo_q,
    output logic [PINS-1:0] ahi_q
);
    typedef struct packed {
        logic [PINS-1:0] dout;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] od;
        logic [PINS-1:0] alo;
        logic [PINS-1:0] ahi;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old_v,
                                              input logic [PINS-1:0] new_v,
                                              input logic [PINS-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                RS_DOUT: r_d.dout = merge(r_q.dout, wdata, mask);
                RS_DIR:  r_d.dir  = merge(r_q.dir,  wdata, mask);
                RS_OD:   r_d.od   = merge(r_q.od,   wdata, mask);
                RS_ALO:  r_d.alo  = merge(r_q.alo,  wdata, mask);
                RS_AHI:  r_d.ahi  = merge(r_q.ahi,  wdata, mask);
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout_q = r_q.dout;
    assign dir_q  = r_q.dir;
    assign od_q   = r_q.od;
    assign alo_q  = r_q.alo;
    assign ahi_q  = r_q.ahi;

    // R2: selected bits of the port output register take the write data
    a_r2_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_DOUT) |=> ((dout_q ^ $past(wdata)) & $past(mask)) == '0);
    // R3: unselected direction bits survive a direction write
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_DIR) |=> ((dir_q ^ $past(dir_q)) & ~$past(mask)) == '0);
    // R10: read-only and unused addresses change no setting
    a_r10_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel >= RS_PIN) |=> $stable(r_q));
    // R1: the cycle after reset, all settings are clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> r_q == '0);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       dout,
    input  logic [PINS-1:0]       dir,
    input  logic [PINS-1:0]       od,
    input  logic [PINS-1:0]       alo,
    input  logic [PINS-1:0]       ahi,
    input  logic [ALT_N*PINS-1:0] alt_out,
    input  logic [ALT_N*PINS-1:0] alt_oe,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe
);
    logic [PINS-1:0] src_v, src_e;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic [1:0] psel;
        assign psel = {ahi[i], alo[i]};

        always_comb begin
            case (psel)
                2'd1:    begin src_v[i] = alt_out[i];          src_e[i] = alt_oe[i];          end
                2'd2:    begin src_v[i] = alt_out[PINS + i];   src_e[i] = alt_oe[PINS + i];   end
                2'd3:    begin src_v[i] = alt_out[2*PINS + i]; src_e[i] = alt_oe[2*PINS + i]; end
                default: begin src_v[i] = dout[i];             src_e[i] = dir[i];             end
            endcase
        end

        assign pad_out[i] = od[i] ? 1'b0 : src_v[i];
        assign pad_oe[i]  = od[i] ? (src_e[i] & ~src_v[i]) : src_e[i];

        // R9: an open-drain pin never drives a high level
        a_r9_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
            (od[i] && pad_oe[i]) |-> !pad_out[i]);
        // R7: a port-sourced push-pull pin follows its direction bit
        a_r7_pp_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (psel == 2'd0 && !od[i]) |-> pad_oe[i] == dir[i]);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PINS   = 8,
    localparam int ADDR_W = PINS + SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PINS-1:0]       bus_wdata,
    output logic [PINS-1:0]       bus_rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    input  logic [ALT_N*PINS-1:0] alt_out,
    input  logic [ALT_N*PINS-1:0] alt_oe,
    output logic [PINS-1:0]       periph_in
);
    regsel_e         sel;
    logic [PINS-1:0] mask;
    logic            wr_en;
    logic [PINS-1:0] dout_q, dir_q, od_q, alo_q, ahi_q, pin_q;
    logic [PINS-1:0] raw_rd;

    assign sel   = regsel_e'(bus_addr[SEL_W-1:0]);
    assign mask  = bus_addr[ADDR_W-1:SEL_W];
    assign wr_en = bus_en & bus_we;

    gpio_regs #(.PINS(PINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .mask(mask),
        .wdata(bus_wdata), .dout_q(dout_q), .dir_q(dir_q), .od_q(od_q),
        .alo_q(alo_q), .ahi_q(ahi_q)
    );

    gpio_sync #(.W(PINS)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_q)
    );

    gpio_pin_mux #(.PINS(PINS)) i_mux (
        .clk(clk), .rst_n(rst_n), .dout(dout_q), .dir(dir_q), .od(od_q),
        .alo(alo_q), .ahi(ahi_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign periph_in = pin_q;

    always_comb begin
        case (sel)
            RS_DOUT: raw_rd = dout_q;
            RS_DIR:  raw_rd = dir_q;
            RS_OD:   raw_rd = od_q;
            RS_ALO:  raw_rd = alo_q;
            RS_AHI:  raw_rd = ahi_q;
            RS_PIN:  raw_rd = pin_q;
            default: raw_rd = '0;
        endcase
    end

    assign bus_rdata = (bus_en && !bus_we) ? (raw_rd & mask) : '0;

    // R4: an idle bus carries no data
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> bus_rdata == '0);
    // R6: peripherals see the same level that software reads
    a_r6_periph_match: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && sel == RS_PIN) |-> bus_rdata == (periph_in & mask));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    localparam int P = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [P+2:0]  bus_addr = '0;
    logic [P-1:0]  bus_wdata = '0, bus_rdata;
    logic [P-1:0]  pad_in = '0, pad_out, pad_oe, periph_in;
    logic [3*P-1:0] alt_out = '0, alt_oe = '0;

    int checks = 0, errors = 0;
    logic [P-1:0] m_dout = '0, m_dir = '0, m_od = '0, m_alo = '0, m_ahi = '0, m_pin = '0;

    gpio_port #(.PINS(P)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .periph_in(periph_in)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [P-1:0] act, logic [P-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [P-1:0] model_reg(int s);
        case (s)
            0: return m_dout;
            1: return m_dir;
            2: return m_od;
            3: return m_alo;
            4: return m_ahi;
            5: return m_pin;
            default: return '0;
        endcase
    endfunction

    function automatic void exp_pads(output logic [P-1:0] po, output logic [P-1:0] oe);
        for (int i = 0; i < P; i++) begin
            int k;
            logic v, e;
            k = {m_ahi[i], m_alo[i]};
            if (k == 0) begin v = m_dout[i]; e = m_dir[i]; end
            else begin v = alt_out[(k-1)*P + i]; e = alt_oe[(k-1)*P + i]; end
            po[i] = m_od[i] ? 1'b0 : v;
            oe[i] = m_od[i] ? (e & ~v) : e;
        end
    endfunction

    task automatic do_write(int s, logic [P-1:0] m, logic [P-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = {m, 3'(s)}; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
        case (s)
            0: m_dout = (m_dout & ~m) | (d & m);
            1: m_dir  = (m_dir  & ~m) | (d & m);
            2: m_od   = (m_od   & ~m) | (d & m);
            3: m_alo  = (m_alo  & ~m) | (d & m);
            4: m_ahi  = (m_ahi  & ~m) | (d & m);
            default: ;
        endcase
    endtask

    task automatic do_read(int s, logic [P-1:0] m, output logic [P-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = {m, 3'(s)};
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic check_pads(string req);
        logic [P-1:0] po, oe;
        #1;
        exp_pads(po, oe);
        check({req, " pad_out"}, pad_out, po);
        check({req, " pad_oe"}, pad_oe, oe);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [P-1:0] rd;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 5; s++) begin
            do_read(s, 8'hFF, rd);
            check("R1 reg after reset", rd, 8'h00);
        end
        check("R1 pad_oe after reset", pad_oe, 8'h00);

        // R3: zero mask changes nothing
        do_write(0, 8'h00, 8'hFF);
        do_read(0, 8'hFF, rd);
        check("R3 zero mask", rd, 8'h00);

        // R2 R3: partial masked write
        do_write(1, 8'h0F, 8'hFF);
        do_write(1, 8'h3C, 8'h00);
        do_read(1, 8'hFF, rd);
        check("R2 R3 dir masked", rd, 8'h03);

        // R7: push-pull port source
        do_write(1, 8'hFF, 8'hFF);
        do_write(0, 8'hFF, 8'hA5);
        check_pads("R7 push-pull");

        // R9: open-drain drives only zeros
        do_write(2, 8'hFF, 8'hFF);
        check_pads("R9 open-drain");
        check("R9 od oe value", pad_oe, 8'h5A);

        // R8: alternates with open-drain on half the pins
        alt_out = 24'hF0_CC_AA; alt_oe = 24'h0F_FF_3C;
        do_write(2, 8'hFF, 8'h0F);
        do_write(3, 8'hFF, 8'b1011_0110);
        do_write(4, 8'hFF, 8'b1101_1100);
        check_pads("R8 alternate source");

        // R10: writes to read-only and unused addresses
        for (int s = 5; s < 8; s++) do_write(s, 8'hFF, ~model_reg(0));
        check_pads("R10 ro write pads");
        for (int s = 0; s < 5; s++) begin
            do_read(s, 8'hFF, rd);
            check("R10 settings kept", rd, model_reg(s));
        end

        // R4: unused addresses read zero
        do_read(6, 8'hFF, rd);
        check("R4 addr6 zero", rd, 8'h00);
        do_read(7, 8'hFF, rd);
        check("R4 addr7 zero", rd, 8'h00);

        // R5 R6: synchronizer latency, edge by edge
        @(negedge clk) pad_in = 8'h69;
        @(posedge clk); #1;
        check("R6 not after one edge", periph_in, m_pin);
        @(posedge clk); #1;
        m_pin = 8'h69;
        check("R6 after two edges", periph_in, 8'h69);
        do_read(5, 8'hF0, rd);
        check("R5 pin read masked", rd, 8'h60);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int s;
            logic [P-1:0] m, d;
            s = $urandom_range(0, 7);
            m = 8'($urandom);
            d = 8'($urandom);
            alt_out = 24'($urandom);
            alt_oe  = 24'($urandom);
            do_write(s, m, d);
            check_pads("R7 R8 R9 random pads");
            s = $urandom_range(0, 7);
            m = 8'($urandom);
            do_read(s, m, rd);
            check("R2 R3 R4 random read", rd, model_reg(s) & m);
            if ((n % 16) == 0) begin
                @(negedge clk) pad_in = 8'($urandom);
                repeat (2) @(posedge clk);
                #1 m_pin = pad_in;
                check("R6 random periph", periph_in, m_pin);
                do_read(5, 8'hFF, rd);
                check("R5 random pin read", rd, m_pin);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule